// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width modulated output from a register-programmed counter. Software writes a period value and pushes duty values into a four-deep sample queue. Each time a new PWM period begins, one queued value is taken and sets the high time of that period only. If the queue is empty at a period boundary, the last value taken is used again. A 12-bit prescaler divides the counting rate. The counter runs from 0 up to the period value and then wraps.

If software pushes a value into a full queue, a write-error flag is latched. While that flag is set, the enable bit does not start the output. A self-clearing reset bit in the control register puts the block back into a clean state. It empties the queue, clears the flags, the counter and the control fields, and reads back as 1 until the reset has finished. The clock-source field is only stored and read back. A debug-permit bit decides whether counting continues while the debug-halt input is high.

Registers are selected by a 2-bit word address: 0 is control, 1 is status, 2 is sample push and 3 is period. Reads are combinational from the address.

Top module: `pwm_fifo_top`

## Requirements
- R1: After reset, control reads 0, status reads 0x08 (queue empty, level 0), the period reads 0 and `pwm_out` is low.
- R2: Status bits [2:0] give the queue level (0 to 4) and bit 3 is 1 exactly when the level is 0. Each accepted sample write raises the level by one.
- R3: A sample write (address 2) while the level is 4 discards the data, leaves the level at 4 and sets the write-error flag at status bit 4.
- R4: While the write-error flag is set, `pwm_out` stays low even with control bit 0 (enable) set.
- R5: Writing control with bit 3 set starts a software reset. Bit 3 then reads 1 for exactly 8 cycles and 0 afterwards. The reset empties the queue, clears the error flag, the period and every control field, and register writes are ignored while it runs.
- R6: With enable set, output starts one cycle after the enable write. Each period lasts (P+1)(D+1) cycles, where P is the period register and D is control bits [15:4]. The output is high for min(S,P+1)(D+1) cycles at the start of the period, where S is the sample taken for that period. Samples are taken in write order.
- R7: When the queue is empty at a period boundary, the previous period's sample is used again.
- R8: Control bits [17:16] (clock source: 1 normal, 2 fast), bit 22 (debug permit), bits [15:4] and bit 0 read back as written. All other control bits, and status bits [31:5], read 0.
- R9: While `dbg_halt` is high and control bit 22 is 0, the counter freezes and `pwm_out` holds its level. With bit 22 set, counting continues during `dbg_halt`.
- R10: Writing status with bit 4 set clears the write-error flag.
- R11: With enable clear for two cycles in a row, `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dbg_halt | input | 1 | Debug halt request |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions take for granted that `bus_addr` and `bus_wdata` carry a meaningful value whenever `bus_wr` is high. They also assume software never writes reserved control bits expecting an effect. Sample pushes are counted against the level only when no software reset is running. The stimulus writes one register per strobe and always starts a software reset before a randomized run. It draws period, prescale and duty values that keep every measured period well inside the run. Queue overfilling is driven only in directed sequences, so the random runs never set the error flag by accident.

// File: rtl/pwm_fifo_pkg.sv
// Package: register addresses, control field positions and shared widths
// for the queued-duty PWM. Assumes a 32-bit register bus.
package pwm_fifo_pkg;
    localparam int BUS_W      = 32;
    localparam int SAMPLE_W   = 16;
    localparam int PRESC_W    = 12;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STAT   = 2'd1;
    localparam logic [1:0] ADDR_SAMPLE = 2'd2;
    localparam logic [1:0] ADDR_PERIOD = 2'd3;

    localparam int CTL_EN     = 0;
    localparam int CTL_SWR    = 3;
    localparam int CTL_PRE_LO = 4;
    localparam int CTL_SRC_LO = 16;
    localparam int CTL_DBG    = 22;

    localparam int STA_EMPTY  = 3;
    localparam int STA_FWE    = 4;
endpackage

// File: rtl/pwm_sample_fifo.sv
// Module: pwm_sample_fifo
// Small queue of duty samples. A push while full is dropped; the caller
// flags the error. Flush empties it in one cycle. Assumes DEPTH is a power
// of two.
module pwm_sample_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    // Pointer and level bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= din;
    end
endmodule

// File: rtl/pwm_counter_core.sv
// Module: pwm_counter_core
// Prescaler, period counter and compare. It takes one sample when it
// starts and at every wrap, reusing the held duty when none is available.
// Assumes 'active' already folds in enable and error gating.
module pwm_counter_core #(
    parameter int SAMPLE_W = 16,
    parameter int PRESC_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                active,
    input  logic                halt,
    input  logic [PRESC_W-1:0]  presc_div,
    input  logic [SAMPLE_W-1:0] period,
    input  logic                sample_avail,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                pop,
    output logic                pwm_out
);
    logic                running;
    logic [PRESC_W-1:0]  presc;
    logic [SAMPLE_W-1:0] cnt, duty;
    logic                tick, wrap, boundary;

    assign tick     = running && !halt && (presc == presc_div);
    assign wrap     = tick && (cnt >= period);
    assign boundary = active && (!running || wrap);
    assign pop      = boundary && sample_avail && !clr;
    assign pwm_out  = running && (cnt < duty);

    // Run state, prescaler, counter and held duty.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            running <= 1'b0;
            presc   <= '0;
            cnt     <= '0;
            duty    <= '0;
        end else if (!active) begin
            running <= 1'b0;
            presc   <= '0;
            cnt     <= '0;
        end else begin
            running <= 1'b1;
            if (boundary && sample_avail) duty <= sample;
            if (!running) begin
                presc <= '0;
                cnt   <= '0;
            end else if (!halt) begin
                if (tick) begin
                    presc <= '0;
                    cnt   <= wrap ? '0 : cnt + 1'b1;
                end else begin
                    presc <= presc + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwm_fifo_top.sv
// Module: pwm_fifo_top
// Register front end of the queued-duty PWM: control, status, sample push
// and period registers, software-reset sequencing and error flag. Assumes
// one register access per strobe; reads are combinational.
module pwm_fifo_top
    import pwm_fifo_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int SWR_CYCLES = 8,
    localparam int LW        = $clog2(DEPTH + 1),
    localparam int SWR_W     = $clog2(SWR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             dbg_halt,
    output logic             pwm_out
);
    logic                en_q, dbg_q, fwe_q;
    logic [1:0]          src_q;
    logic [PRESC_W-1:0]  presc_q;
    logic [SAMPLE_W-1:0] period_q;
    logic [SWR_W-1:0]    swr_cnt;
    logic                swr_busy, swr_start, soft_clr;
    logic                wr_ctrl, wr_stat, wr_samp, wr_per;
    logic [SAMPLE_W-1:0] fifo_dout;
    logic [LW-1:0]       fifo_level;
    logic                fifo_full, fifo_empty, fifo_pop;

    assign swr_busy  = (swr_cnt != '0);
    assign wr_ctrl   = bus_wr && !swr_busy && (bus_addr == ADDR_CTRL);
    assign wr_stat   = bus_wr && !swr_busy && (bus_addr == ADDR_STAT);
    assign wr_samp   = bus_wr && !swr_busy && (bus_addr == ADDR_SAMPLE);
    assign wr_per    = bus_wr && !swr_busy && (bus_addr == ADDR_PERIOD);
    assign swr_start = wr_ctrl && bus_wdata[CTL_SWR];
    assign soft_clr  = swr_start || swr_busy;

    // Control and period registers, software-reset countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; dbg_q <= 1'b0; src_q <= '0; presc_q <= '0;
            period_q <= '0; swr_cnt <= '0;
        end else if (swr_busy) begin
            swr_cnt <= swr_cnt - 1'b1;
        end else if (swr_start) begin
            en_q <= 1'b0; dbg_q <= 1'b0; src_q <= '0; presc_q <= '0;
            period_q <= '0; swr_cnt <= SWR_W'(SWR_CYCLES);
        end else begin
            if (wr_ctrl) begin
                en_q    <= bus_wdata[CTL_EN];
                dbg_q   <= bus_wdata[CTL_DBG];
                src_q   <= bus_wdata[CTL_SRC_LO +: 2];
                presc_q <= bus_wdata[CTL_PRE_LO +: PRESC_W];
            end
            if (wr_per) period_q <= bus_wdata[SAMPLE_W-1:0];
        end
    end

    // Write-error flag: set on push into a full queue, cleared by W1C or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr)                 fwe_q <= 1'b0;
        else if (wr_samp && fifo_full)          fwe_q <= 1'b1;
        else if (wr_stat && bus_wdata[STA_FWE]) fwe_q <= 1'b0;
    end

    pwm_sample_fifo #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_clr),
        .push  (wr_samp),
        .din   (bus_wdata[SAMPLE_W-1:0]),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwm_counter_core #(.SAMPLE_W(SAMPLE_W), .PRESC_W(PRESC_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (soft_clr),
        .active       (en_q && !fwe_q),
        .halt         (dbg_halt && !dbg_q),
        .presc_div    (presc_q),
        .period       (period_q),
        .sample_avail (!fifo_empty),
        .sample       (fifo_dout),
        .pop          (fifo_pop),
        .pwm_out      (pwm_out)
    );

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTL_EN]                 = en_q;
                bus_rdata[CTL_SWR]                = swr_busy;
                bus_rdata[CTL_PRE_LO +: PRESC_W]  = presc_q;
                bus_rdata[CTL_SRC_LO +: 2]        = src_q;
                bus_rdata[CTL_DBG]                = dbg_q;
            end
            ADDR_STAT: begin
                bus_rdata[2:0]       = 3'(fifo_level);
                bus_rdata[STA_EMPTY] = fifo_empty;
                bus_rdata[STA_FWE]   = fwe_q;
            end
            ADDR_PERIOD: bus_rdata[SAMPLE_W-1:0] = period_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_fifo_checker.sv
// Module: pwm_fifo_checker
// Temporal checks on the queued-duty PWM, bound into pwm_fifo_top.
// Assumes the bus carries valid data whenever bus_wr is high.
module pwm_fifo_checker #(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic          en_q,
    input logic          fwe_q,
    input logic          swr_busy,
    input logic [LW-1:0] fifo_level,
    input logic          pwm_out
);
    a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level > $past(fifo_level)) |-> (fifo_level == $past(fifo_level) + 1'b1));

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !swr_busy && fifo_level == LW'(DEPTH))
        |=> (fwe_q && fifo_level == LW'(DEPTH)));

    a_r4_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fwe_q && $past(fwe_q)) |-> !pwm_out);

    a_r5_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        swr_busy |-> (fifo_level == '0 && !pwm_out && !en_q && !fwe_q));

    a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $past(!en_q)) |-> !pwm_out);
endmodule

bind pwm_fifo_top pwm_fifo_checker #(.DEPTH(DEPTH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .en_q       (en_q),
    .fwe_q      (fwe_q),
    .swr_busy   (swr_busy),
    .fifo_level (fifo_level),
    .pwm_out    (pwm_out)
);

// File: tb/pwm_fifo_top_tb.sv
`timescale 1ns/1ps
// Bench for pwm_fifo_top: directed corners plus seeded random duty runs.
module pwm_fifo_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        pwm_out;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    pwm_fifo_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .pwm_out(pwm_out)
    );

    function automatic int exp_high(int duty, int per, int div);
        int d = (duty < per + 1) ? duty : per + 1;
        return d * (div + 1);
    endfunction

    function automatic logic [31:0] ctl(bit en, int div, int src, bit dbg);
        return 32'(en) | (32'(div) << 4) | (32'(src) << 16) | (32'(dbg) << 22);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic soft_reset();
        wr(2'd0, 32'h8);
        repeat (9) @(negedge clk);
    endtask

    // Enable already written: step to first running cycle and count highs.
    task automatic measure(int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hi;
        int per, div, n;
        int duties [4];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdreg(2'd0, rd); check("R1 ctrl", rd, 32'h0);
        rdreg(2'd1, rd); check("R1 status", rd, 32'h8);
        rdreg(2'd3, rd); check("R1 period", rd, 32'h0);
        check("R1 out", 32'(pwm_out), 32'h0);

        // R8 readback and reserved bits
        wr(2'd0, ctl(0, 5, 2, 1));
        rdreg(2'd0, rd); check("R8 fields", rd, 32'h0042_0050);
        wr(2'd0, 32'hFFFF_FFF7);
        rdreg(2'd0, rd); check("R8 reserved", rd, 32'h0043_FFF1);
        wr(2'd0, 32'h0);
        rdreg(2'd1, rd); check("R8 status reserved", rd & 32'hFFFF_FFE0, 32'h0);

        // R2 level counting
        wr(2'd2, 32'd3);
        rdreg(2'd1, rd); check("R2 level1", rd, 32'h1);
        wr(2'd2, 32'd4); wr(2'd2, 32'd5); wr(2'd2, 32'd6);
        rdreg(2'd1, rd); check("R2 level4", rd, 32'h4);

        // R3 overflow sets error, level stays 4
        wr(2'd2, 32'd7);
        rdreg(2'd1, rd); check("R3 overflow", rd, 32'h14);

        // R4 enable blocked while error set
        wr(2'd3, 32'd5);
        wr(2'd0, 32'h1);
        measure(40, hi);
        check("R4 blocked", 32'(hi), 32'h0);

        // R10 W1C clears error
        wr(2'd1, 32'h10);
        rdreg(2'd1, rd); check("R10 w1c", rd & 32'h10, 32'h0);

        // R5 soft reset timing and clearing
        wr(2'd0, 32'h8);
        for (int i = 0; i < 8; i++) begin
            rdreg(2'd0, rd); check("R5 busy", rd, 32'h8);
            @(negedge clk);
        end
        rdreg(2'd0, rd); check("R5 done", rd, 32'h0);
        rdreg(2'd1, rd); check("R5 status", rd, 32'h8);
        rdreg(2'd3, rd); check("R5 period", rd, 32'h0);
        check("R5 out", 32'(pwm_out), 32'h0);
        // R5 writes ignored while running
        wr(2'd0, 32'h8);
        wr(2'd3, 32'd9);
        repeat (8) @(negedge clk);
        rdreg(2'd3, rd); check("R5 write ignored", rd, 32'h0);

        // R6/R7 directed: duty 0 and duty above period
        wr(2'd2, 32'd0); wr(2'd2, 32'd20);
        wr(2'd3, 32'd7);
        wr(2'd0, ctl(1, 1, 1, 0));
        @(negedge clk);
        measure(16, hi); check("R6 duty zero", 32'(hi), 32'(exp_high(0, 7, 1)));
        measure(16, hi); check("R6 duty full", 32'(hi), 32'(exp_high(20, 7, 1)));
        measure(16, hi); check("R7 reuse", 32'(hi), 32'(exp_high(20, 7, 1)));
        wr(2'd0, 32'h0);
        @(negedge clk);
        check("R11 idle low", 32'(pwm_out), 32'h0);

        // R9 debug halt freeze and permit
        soft_reset();
        wr(2'd2, 32'd5);
        wr(2'd3, 32'd9);
        wr(2'd0, ctl(1, 0, 1, 0));
        @(negedge clk);
        repeat (3) @(negedge clk);
        dbg_halt = 1'b1;
        measure(30, hi); check("R9 frozen high", 32'(hi), 32'd30);
        dbg_halt = 1'b0;
        wr(2'd0, 32'h8);
        repeat (9) @(negedge clk);
        wr(2'd2, 32'd4);
        wr(2'd3, 32'd9);
        dbg_halt = 1'b1;
        wr(2'd0, ctl(1, 0, 1, 1));
        @(negedge clk);
        measure(10, hi); check("R9 permit runs", 32'(hi), 32'd4);
        dbg_halt = 1'b0;

        // R6/R7 random runs
        for (int it = 0; it < 8; it++) begin
            soft_reset();
            per = 3 + int'($urandom % 18);
            div = int'($urandom % 4);
            n   = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) begin
                duties[k] = int'($urandom % (per + 3));
                wr(2'd2, 32'(duties[k]));
            end
            wr(2'd3, 32'(per));
            wr(2'd0, ctl(1, div, 1 + int'($urandom % 2), 0));
            @(negedge clk);
            for (int k = 0; k < n; k++) begin
                measure((per + 1) * (div + 1), hi);
                check("R6 random period", 32'(hi), 32'(exp_high(duties[k], per, div)));
            end
            measure((per + 1) * (div + 1), hi);
            check("R7 random reuse", 32'(hi), 32'(exp_high(duties[n-1], per, div)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule